// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Handshake

This block is a full-duplex synchronous serial port. It moves 8-bit characters out on a data line and in on a second data line. Both directions share one serial clock. That clock is either produced inside the block from the system clock, through a prescaler and an 8-bit divisor, or taken from a pin. A one-character transmit buffer feeds a transmit shift register, and a receive shift register feeds a one-character receive buffer. Software-level control arrives as static configuration inputs, plus single-cycle write and read strobes for the two buffers.

Several options are set at run time:
- bit order;
- clock polarity;
- logical inversion of the data lines;
- optional clear-to-send or request-to-send handshaking;
- the event that raises the transmit interrupt pulse.

A receive overrun is flagged early, on the seventh bit of the following character. In continuous-receive mode, a read of the receive buffer re-arms the transmit buffer, so the port keeps clocking frames to collect more data without further writes.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, tx_empty_o=1, rx_full_o=0, overrun_o=0, both interrupt pulses are 0, rts_no=1 and sclk_o sits at its idle level, which is high for clk_pol_i=0 and low for clk_pol_i=1.
- R2: With the internal clock, each half period of sclk_o lasts (brg_i+1)*D system cycles. D depends on clk_src_i: 0 gives D=1; 1 gives D=8; 2 gives D=1 when psc_i=0 and D=2*psc_i otherwise.
- R3: A frame carries exactly 8 bits. For clk_pol_i=0, data is launched on falling and sampled on rising sclk edges. For clk_pol_i=1, these edges are swapped. With msb_first_i=0, bit 0 goes first. With msb_first_i=1, bit 7 goes first.
- R4: A frame starts only when tx_en_i=1 and tx_empty_o=0. When flow_i=1 (clear-to-send), cts_ni must also be low. Otherwise the buffered character waits and the serial clock stays idle.
- R5: With flow_i=2 (request-to-send) and the internal clock, rts_no is low only when tx_en_i=1, tx_empty_o=0, rx_en_i=1 and rx_full_o=0. With flow_i=2 and the external clock, rts_no is low when rx_en_i=1 and rx_full_o=0. For any other flow_i value, rts_no stays high.
- R6: With tx_irq_sel_i=0, tx_irq_o pulses when the buffer moves into the shift register. With tx_irq_sel_i=1, it pulses when the eighth bit has been sampled. Each pulse lasts one cycle.
- R7: A completed character moves into rx_data_o, which sets rx_full_o and pulses rx_irq_o. A pulse on rx_rd_i clears rx_full_o.
- R8: Transmission runs with rx_en_i=0. In that case rx_full_o stays 0 and rx_irq_o never pulses.
- R9: If rx_full_o is still set when the seventh bit of the next character is sampled, overrun_o is set. That character is not loaded into rx_data_o and raises no rx_irq_o. overrun_o stays set until rx_en_i goes low.
- R10: With invert_i=1, transmitted bits and received bits are both complemented.
- R11: With cont_rx_i=1, a pulse on rx_rd_i clears tx_empty_o, so the buffered character is sent again as a further frame.
- R12: With clk_ext_i=1, sclk_i is synchronized through two flops. Its edges drive launch and sampling under the same clk_pol_i rule, and sclk_o stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| clk_ext_i | input | 1 | 1: serial clock from sclk_i |
| clk_pol_i | input | 1 | Serial clock polarity |
| msb_first_i | input | 1 | Bit order select |
| invert_i | input | 1 | Data inversion |
| cont_rx_i | input | 1 | Continuous-receive mode |
| tx_irq_sel_i | input | 1 | 0: irq on buffer transfer, 1: irq on frame end |
| flow_i | input | 2 | 0 none, 1 clear-to-send, 2 request-to-send |
| clk_src_i | input | 2 | Divider source select |
| psc_i | input | PSC_W | Prescaler setting |
| brg_i | input | BRG_W | Divisor setting |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | W | Transmit buffer write data |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_data_o | output | W | Receive buffer |
| tx_empty_o | output | 1 | Transmit buffer empty |
| rx_full_o | output | 1 | Receive buffer full |
| overrun_o | output | 1 | Sticky overrun flag |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Internal serial clock |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| cts_ni | input | 1 | Clear-to-send, active low |
| rts_no | output | 1 | Request-to-send, active low |

## Verification
The bench builds the block with its default parameters: W=8, PSC_W=4, BRG_W=8, two synchronizer stages and a fixed divide-by-8 source. It keeps the divisor small, so a 16-edge frame lasts at most a few hundred cycles. That makes all three divider sources, a nonzero prescaler, overrun across two frames and a continuous-receive chain all reachable in a short run. A bus-peer model answers on sd_i and records sd_o from the real sclk_o edges, so bit order, polarity and inversion are checked on the wire and not inside the block. Divisor values near 0xFF are not exercised, because they only stretch time.

// File: rtl/sync_serial_pkg.sv
`timescale 1ns/1ps
package sync_serial_pkg;
  typedef enum logic [1:0] {
    FLOW_NONE = 2'd0,
    FLOW_CTS  = 2'd1,
    FLOW_RTS  = 2'd2
  } flow_e;

  typedef enum logic [1:0] {
    SRC_F1  = 2'd0,
    SRC_F8  = 2'd1,
    SRC_PSC = 2'd2
  } src_e;
endpackage

// File: rtl/sserial_clkgen.sv
`timescale 1ns/1ps
module sserial_clkgen
  import sync_serial_pkg::*;
#(
  parameter int PSC_W       = 4,
  parameter int BRG_W       = 8,
  parameter int F8_DIV      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_i,
  input  logic             pol_i,
  input  logic             run_i,
  input  logic [1:0]       src_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             sclk_pin_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             sample_o
);
  localparam int DIV_W = PSC_W + 2;

  logic [DIV_W-1:0] div, pre_q;
  logic [BRG_W-1:0] brg_q;
  logic             sclk_q, idle, fj_en, tick;

  assign idle = ~pol_i;

  always_comb begin
    case (src_i)
      SRC_F1:  div = DIV_W'(1);
      SRC_F8:  div = DIV_W'(F8_DIV);
      SRC_PSC: div = (psc_i == '0) ? DIV_W'(1) : DIV_W'({psc_i, 1'b0});
      default: div = DIV_W'(1);
    endcase
  end

  assign fj_en = run_i && !ext_i && (pre_q == div - DIV_W'(1));
  assign tick  = fj_en && (brg_q == brg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      brg_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i || ext_i) begin
      pre_q  <= '0;
      brg_q  <= '0;
      sclk_q <= idle;
    end else begin
      pre_q <= fj_en ? '0 : pre_q + DIV_W'(1);
      if (fj_en) brg_q <= (brg_q == brg_i) ? '0 : brg_q + BRG_W'(1);
      if (tick) sclk_q <= ~sclk_q;
    end
  end

  // external pin synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= sclk_pin_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  assign sclk_o   = sclk_q;
  assign launch_o = ext_i ? (pol_i ? rise : fall) : (tick && (sclk_q == idle));
  assign sample_o = ext_i ? (pol_i ? fall : rise) : (tick && (sclk_q != idle));
endmodule

// File: rtl/sserial_tx.sv
`timescale 1ns/1ps
module sserial_tx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         start_ok_i,
  input  logic         rearm_i,
  input  logic         launch_i,
  input  logic         sample_i,
  input  logic         msb_first_i,
  input  logic         inv_i,
  input  logic         irq_sel_i,
  output logic         empty_o,
  output logic         busy_o,
  output logic         sd_o,
  output logic         irq_o
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     buf_q, sh_q;
  logic [CNT_W-1:0] lcnt_q, scnt_q, idx;
  logic             empty_q, busy_q, sd_q, irq_q, load;

  assign load = start_ok_i && !empty_q && !busy_q;
  assign idx  = msb_first_i ? CNT_W'(W-1) - lcnt_q : lcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      sh_q    <= '0;
      lcnt_q  <= '0;
      scnt_q  <= '0;
      empty_q <= 1'b1;
      busy_q  <= 1'b0;
      sd_q    <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (load) begin
        sh_q    <= buf_q;
        empty_q <= 1'b1;
        busy_q  <= 1'b1;
        lcnt_q  <= '0;
        scnt_q  <= '0;
        if (!irq_sel_i) irq_q <= 1'b1;
      end else if (busy_q) begin
        if (launch_i) begin
          sd_q   <= sh_q[idx] ^ inv_i;
          lcnt_q <= lcnt_q + CNT_W'(1);
        end
        if (sample_i) begin
          if (scnt_q == CNT_W'(W-1)) begin
            busy_q <= 1'b0;
            if (irq_sel_i) irq_q <= 1'b1;
          end
          scnt_q <= scnt_q + CNT_W'(1);
        end
      end
      // a write or re-arm after a same-cycle load must win
      if (rearm_i) empty_q <= 1'b0;
      if (wr_i) begin
        buf_q   <= data_i;
        empty_q <= 1'b0;
      end
    end
  end

  assign empty_o = empty_q;
  assign busy_o  = busy_q;
  assign sd_o    = sd_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/sserial_rx.sv
`timescale 1ns/1ps
module sserial_rx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sample_i,
  input  logic         sd_i,
  input  logic         msb_first_i,
  input  logic         inv_i,
  input  logic         rd_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         ovr_o,
  output logic         irq_o
);
  localparam int CNT_W   = $clog2(W);
  localparam int OVR_IDX = W - 2;  // zero-based index of the next-to-last bit

  logic [W-1:0]     sh_q, sh_nx, data_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bit_in, full_q, ovr_q, ovr_frm_q, irq_q;

  assign bit_in = sd_i ^ inv_i;
  assign sh_nx  = msb_first_i ? {sh_q[W-2:0], bit_in} : {bit_in, sh_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      data_q    <= '0;
      cnt_q     <= '0;
      full_q    <= 1'b0;
      ovr_q     <= 1'b0;
      ovr_frm_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (rd_i) full_q <= 1'b0;
      if (!en_i) begin
        cnt_q     <= '0;
        ovr_q     <= 1'b0;
        ovr_frm_q <= 1'b0;
      end else if (sample_i) begin
        sh_q <= sh_nx;
        if (cnt_q == CNT_W'(W-1)) begin
          cnt_q     <= '0;
          ovr_frm_q <= 1'b0;
          if (!ovr_frm_q) begin
            data_q <= sh_nx;
            full_q <= 1'b1;
            irq_q  <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(OVR_IDX) && full_q && !rd_i) begin
            ovr_q     <= 1'b1;
            ovr_frm_q <= 1'b1;
          end
        end
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sync_serial_xcvr.sv
`timescale 1ns/1ps
module sync_serial_xcvr
  import sync_serial_pkg::*;
#(
  parameter int W           = 8,
  parameter int PSC_W       = 4,
  parameter int BRG_W       = 8,
  parameter int F8_DIV      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             clk_ext_i,
  input  logic             clk_pol_i,
  input  logic             msb_first_i,
  input  logic             invert_i,
  input  logic             cont_rx_i,
  input  logic             tx_irq_sel_i,
  input  logic [1:0]       flow_i,
  input  logic [1:0]       clk_src_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             tx_wr_i,
  input  logic [W-1:0]     tx_data_i,
  input  logic             rx_rd_i,
  output logic [W-1:0]     rx_data_o,
  output logic             tx_empty_o,
  output logic             rx_full_o,
  output logic             overrun_o,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  input  logic             sclk_i,
  output logic             sclk_o,
  input  logic             sd_i,
  output logic             sd_o,
  input  logic             cts_ni,
  output logic             rts_no
);
  logic busy, launch, sample, cts_ok, start_ok, rearm, rts_ready;

  assign cts_ok   = (flow_i != FLOW_CTS) || !cts_ni;
  assign start_ok = tx_en_i && cts_ok;
  assign rearm    = rx_rd_i && cont_rx_i;

  sserial_clkgen #(
    .PSC_W(PSC_W), .BRG_W(BRG_W), .F8_DIV(F8_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_clk (
    .clk_i, .rst_ni,
    .ext_i(clk_ext_i), .pol_i(clk_pol_i), .run_i(busy),
    .src_i(clk_src_i), .psc_i, .brg_i,
    .sclk_pin_i(sclk_i), .sclk_o,
    .launch_o(launch), .sample_o(sample)
  );

  sserial_tx #(.W(W)) u_tx (
    .clk_i, .rst_ni,
    .wr_i(tx_wr_i), .data_i(tx_data_i),
    .start_ok_i(start_ok), .rearm_i(rearm),
    .launch_i(launch), .sample_i(sample),
    .msb_first_i, .inv_i(invert_i), .irq_sel_i(tx_irq_sel_i),
    .empty_o(tx_empty_o), .busy_o(busy), .sd_o, .irq_o(tx_irq_o)
  );

  sserial_rx #(.W(W)) u_rx (
    .clk_i, .rst_ni,
    .en_i(rx_en_i), .sample_i(sample), .sd_i,
    .msb_first_i, .inv_i(invert_i), .rd_i(rx_rd_i),
    .data_o(rx_data_o), .full_o(rx_full_o), .ovr_o(overrun_o), .irq_o(rx_irq_o)
  );

  always_comb begin
    rts_ready = rx_en_i && !rx_full_o;
    if (!clk_ext_i) rts_ready = rts_ready && tx_en_i && !tx_empty_o;
  end

  assign rts_no = !((flow_i == FLOW_RTS) && rts_ready);
endmodule

// File: rtl/sync_serial_xcvr_chk.sv
`timescale 1ns/1ps
module sync_serial_xcvr_chk
  import sync_serial_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       rx_en_i,
  input logic       clk_ext_i,
  input logic [1:0] flow_i,
  input logic       cts_ni,
  input logic       rts_no,
  input logic       tx_empty_o,
  input logic       rx_full_o,
  input logic       overrun_o,
  input logic       tx_irq_o,
  input logic       rx_irq_o
);
  a_r4_cts_gates_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_empty_o) && flow_i == FLOW_CTS) |-> ($past(!cts_ni) && $past(tx_en_i)));

  a_r5_rts_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_i == FLOW_RTS && !clk_ext_i && !rts_no) |->
      (tx_en_i && !tx_empty_o && rx_en_i && !rx_full_o));

  a_r6_tx_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);

  a_r7_rx_irq_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_full_o);

  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && rx_en_i) |=> overrun_o);

  a_r8_no_rx_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !rx_full_o) |=> !rx_irq_o);
endmodule

bind sync_serial_xcvr sync_serial_xcvr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .rx_en_i(rx_en_i),
  .clk_ext_i(clk_ext_i), .flow_i(flow_i), .cts_ni(cts_ni), .rts_no(rts_no),
  .tx_empty_o(tx_empty_o), .rx_full_o(rx_full_o), .overrun_o(overrun_o),
  .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
);

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       tx_en = 0, rx_en = 0, clk_ext = 0, pol = 0, msb = 0, inv = 0, cont = 0, isel = 0;
  logic [1:0] flow = 0, src = 0;
  logic [3:0] psc = 0;
  logic [7:0] brg = 0, tx_data = 0, rx_data;
  logic       tx_wr = 0, rx_rd = 0, sclk_in = 0, ext_sd = 0, peer_sd = 0, cts_n = 1;
  logic       tx_empty, rx_full, ovr, tx_irq, rx_irq, sclk_o, sd_o, rts_n, sd_in;

  assign sd_in = clk_ext ? ext_sd : peer_sd;

  sync_serial_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en), .clk_ext_i(clk_ext),
    .clk_pol_i(pol), .msb_first_i(msb), .invert_i(inv), .cont_rx_i(cont),
    .tx_irq_sel_i(isel), .flow_i(flow), .clk_src_i(src), .psc_i(psc), .brg_i(brg),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .tx_empty_o(tx_empty), .rx_full_o(rx_full), .overrun_o(ovr), .tx_irq_o(tx_irq),
    .rx_irq_o(rx_irq), .sclk_i(sclk_in), .sclk_o(sclk_o), .sd_i(sd_in), .sd_o(sd_o),
    .cts_ni(cts_n), .rts_no(rts_n));

  int n_chk = 0, n_bad = 0, cyc = 0, done = 0;
  logic [7:0] txq[$], rxq[$];
  logic [7:0] peer_wire = 0, wire_cap = 0;
  int pbit = 0, wbit = 0, tot_samp = 0, tog = 0, t_first = 0, gap = 0, irq_samp = -1;
  logic sclk_prev = 1'b1;

  function automatic logic [7:0] to_wire(logic [7:0] d);
    logic [7:0] w;
    for (int k = 0; k < 8; k++) w[k] = (msb ? d[7-k] : d[k]) ^ inv;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (done == 0) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // bus peer and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !clk_ext && sclk_o != sclk_prev) begin
      tog++;
      if (tog == 1) t_first = cyc;
      if (tog == 2) gap = cyc - t_first;
      if (sclk_o == pol) begin
        peer_sd = peer_wire[pbit];
        pbit = (pbit + 1) % 8;
      end else begin
        wire_cap[wbit] = sd_o;
        wbit++;
        tot_samp++;
        if (wbit == 8) begin
          wbit = 0;
          if (txq.size() == 0) chk("R3 unexpected frame", 1, 0);
          else chk("R3/R10 tx wire bits", wire_cap, txq.pop_front());
        end
      end
    end
    sclk_prev = sclk_o;
    if (tx_irq) irq_samp = tot_samp;
    if (rx_irq) begin
      if (rxq.size() == 0) chk("R7/R9 unexpected rx_irq", 1, 0);
      else chk("R7 rx data", rx_data, rxq.pop_front());
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic wait_samp(int target);
    for (int i = 0; i < 5000 && tot_samp < target; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // one internal-clock frame: tx byte d, peer sends byte p
  task automatic frame(logic [7:0] d, logic [7:0] p, bit expect_rx);
    int base;
    base = tot_samp;
    pbit = 0; wbit = 0; tog = 0;
    peer_wire = to_wire(p);
    txq.push_back(to_wire(d));
    if (expect_rx) rxq.push_back(p);
    wr(d);
    wait_samp(base + 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 overrun", ovr, 0);
    chk("R1 irqs", {tx_irq, rx_irq}, 0);
    chk("R1 rts_no", rts_n, 1);
    chk("R1 sclk idle", sclk_o, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // basic lsb-first, pol 0
    tx_en = 1; rx_en = 1;
    frame(8'h3C, 8'hA5, 1);
    chk("R7 rx_full set", rx_full, 1);
    rd();
    chk("R7 rx_full cleared by read", rx_full, 0);

    // msb-first, pol 1, inverted
    pol = 1; msb = 1; inv = 1;
    repeat (2) @(negedge clk);
    chk("R1/R3 sclk idle low for pol 1", sclk_o, 0);
    sclk_prev = sclk_o;
    frame(8'h96, 8'h1D, 1);
    rd();
    pol = 0; inv = 0;
    repeat (2) @(negedge clk);
    sclk_prev = sclk_o;
    frame(8'hC1, 8'h72, 1);
    rd();
    msb = 0;

    // divider rates
    src = 1; brg = 3;
    frame(8'h55, 8'h0F, 1); rd();
    chk("R2 f/8 brg 3 half period", gap, 32);
    src = 2; psc = 0; brg = 2;
    frame(8'h81, 8'hF0, 1); rd();
    chk("R2 prescale 0 brg 2 half period", gap, 3);
    psc = 3; brg = 1;
    frame(8'h18, 8'h42, 1); rd();
    chk("R2 prescale 3 brg 1 half period", gap, 12);
    src = 0; brg = 0;

    // tx irq timing
    isel = 0; base = tot_samp;
    frame(8'h01, 8'h02, 1); rd();
    chk("R6 irq at transfer", irq_samp, base);
    isel = 1; base = tot_samp;
    frame(8'h04, 8'h08, 1); rd();
    chk("R6 irq at frame end", irq_samp, base + 8);
    isel = 0;

    // start gating
    tx_en = 0; base = tot_samp;
    pbit = 0; wbit = 0; peer_wire = to_wire(8'h33);
    wr(8'hE7);
    repeat (40) @(negedge clk);
    chk("R4 held while tx disabled", tot_samp, base);
    flow = 1; tx_en = 1;
    repeat (40) @(negedge clk);
    chk("R4 held while cts high", tot_samp, base);
    chk("R4 buffer still full", tx_empty, 0);
    txq.push_back(to_wire(8'hE7)); rxq.push_back(8'h33);
    cts_n = 0;
    wait_samp(base + 8);
    chk("R4 frame after cts low", tot_samp, base + 8);
    rd();
    flow = 0; cts_n = 1;

    // rts
    flow = 2; tx_en = 0;
    wr(8'h6A);
    #1 chk("R5 rts high without tx_en", rts_n, 1);
    pbit = 0; wbit = 0; peer_wire = to_wire(8'h99);
    txq.push_back(to_wire(8'h6A)); rxq.push_back(8'h99);
    base = tot_samp;
    @(negedge clk); tx_en = 1;
    #1 chk("R5 rts low when all four hold", rts_n, 0);
    wait_samp(base + 8);
    chk("R5 rts high while rx full", rts_n, 1);
    rd();
    clk_ext = 1;
    #1 chk("R5 ext rts low when rx ready", rts_n, 0);
    rx_en = 0;
    #1 chk("R5 ext rts high when rx off", rts_n, 1);
    clk_ext = 0; flow = 0;
    repeat (2) @(negedge clk);

    // transmit only
    frame(8'hBE, 8'hEF, 0);
    chk("R8 rx_full stays clear", rx_full, 0);
    rx_en = 1;

    // overrun
    frame(8'h11, 8'h5A, 1);
    frame(8'h22, 8'hC3, 0);
    chk("R9 overrun set", ovr, 1);
    chk("R9 buffer kept", rx_data, 8'h5A);
    rd();
    chk("R9 overrun sticky after read", ovr, 1);
    @(negedge clk); rx_en = 0;
    @(negedge clk); rx_en = 1;
    chk("R9 overrun cleared by rx off", ovr, 0);

    // continuous receive
    cont = 1;
    frame(8'h7E, 8'h24, 1);
    txq.push_back(to_wire(8'h7E)); rxq.push_back(8'h24);
    base = tot_samp; pbit = 0;
    rd();
    wait_samp(base + 8);
    chk("R11 dummy frame after read", tot_samp, base + 8);
    cont = 0; base = tot_samp;
    rd();
    repeat (30) @(negedge clk);
    chk("R11 no frame without cont", tot_samp, base);
    chk("R11 tx_empty stays set", tx_empty, 1);

    // external clock, pol 1 lsb-first
    begin
      logic [7:0] pw, cap;
      pol = 1; sclk_in = 0;
      repeat (2) @(negedge clk);
      clk_ext = 1;
      repeat (4) @(negedge clk);
      pw = to_wire(8'h6B);
      rxq.push_back(8'h6B);
      wr(8'h4E);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); sclk_in = 1; ext_sd = pw[k];
        repeat (8) @(negedge clk);
        sclk_in = 0; cap[k] = sd_o;
        repeat (8) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk("R12 ext tx wire bits", cap, to_wire(8'h4E));
      chk("R12 ext rx full", rx_full, 1);
      chk("R12 sclk_o idle in ext", sclk_o, 0);
    end

    repeat (4) @(negedge clk);
    chk("R7 all expected rx seen", rxq.size(), 0);
    chk("R3 all expected frames seen", txq.size(), 0);
    summary();
  end
endmodule